// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. Software sets a coarse timeout and a clock divider, then enables the timer. After that it must keep writing a fixed magic word to the restart register, or the down-counter reaches zero. At zero the block raises a sticky status flag. Depending on the mode bits, it then drives an interrupt level, a reset pulse of programmable length, or both.

The mode and counter-control registers accept a write only when the write carries a fixed key in its upper bits. A stray store therefore cannot reconfigure or disable the timer. The restart register acts only on one exact 32-bit value. The timeout is coarse: a 12-bit reload field forms the upper bits of the counter, and the lower `LOW_BITS` bits reload as zero. Each counter step takes one prescaler period of 8, 64, 512 or 4096 bus clocks.

Top module: `keyed_watchdog`

## Requirements
- R1: The mode register at byte offset 0x0 accepts a write only when write bits 23:12 equal 0xABC. Its fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, bits 5:4 pulse length. A read at 0x0 returns these fields in the same positions, with all other bits zero. A write with any other key changes nothing.
- R2: The counter-control register at 0x4 accepts a write only when write bits 25:14 equal 0x248. Its fields are: bits 13:2 the 12-bit reload field, bits 1:0 the prescaler select. A read at 0x4 returns these fields in the same positions. A write with any other key changes nothing.
- R3: A write of exactly 0x00001999 to 0x8 does three things: it reloads the counter with reload field × 2^LOW_BITS, it restarts the prescaler, and it clears the zero flag. A write of any other value to 0x8 has no effect.
- R4: The block expires exactly reload × 2^LOW_BITS × D bus-clock edges after the enabling write or the last restart. D is 8, 64, 512 or 4096 for prescaler select 0, 1, 2 or 3.
- R5: Status bit 0, read at 0xC, is set at expiry. It stays set while the count rests at zero, until a restart or a disable clears it.
- R6: `wdt_irq` is high exactly when the zero flag is set and interrupt enable is 1.
- R7: When reset-output enable is 1, `wdt_rst_out` goes high at expiry for 2, 4, 8 or 16 consecutive cycles, for pulse length 0, 1, 2 or 3. When reset-output enable is 0, `wdt_rst_out` stays low.
- R8: A keyed mode write with enable 0 stops counting and clears the zero flag. A later keyed write with enable 1 starts counting from the full reload value.
- R9: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| wdt_rst_out | output | 1 | Timeout reset pulse |
| wdt_irq | output | 1 | Timeout interrupt level |

## Verification
A wrong prescaler or counter state shows up as an expiry that comes early or late. Every timeout is checked at the exact edge: the flag must be clear one cycle before expiry and set at expiry, so a count that is off by one cycle is caught in the same run. A key decoder that lets a wrong write through changes the register readback at once, on the next read. A pulse counter with the wrong state lengthens or shortens `wdt_rst_out` by whole cycles, and the check counts every cycle of the pulse.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W   = 4,
  parameter int LOW_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_out,
  output logic              wdt_irq
);
  localparam int FIELD_W = 12;
  localparam int CNT_W   = FIELD_W + LOW_BITS;
  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [11:0] CTRL_KEY = 12'h248;
  localparam logic [31:0] KICK_WORD = 32'h0000_1999;

  logic               en_q, rst_en_q, irq_en_q;
  logic [1:0]         len_q, psel_q;
  logic [FIELD_W-1:0] reload_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [11:0]        pre_q, pre_lim;
  logic               zflag_q;
  logic [4:0]         pulse_q;

  wire [1:0] reg_idx  = bus_addr[3:2];
  wire mode_acc  = bus_wr && reg_idx == 2'd0 && bus_wdata[23:12] == MODE_KEY;
  wire ctrl_acc  = bus_wr && reg_idx == 2'd1 && bus_wdata[25:14] == CTRL_KEY;
  wire kick_acc  = bus_wr && reg_idx == 2'd2 && bus_wdata == KICK_WORD;
  wire stop_req  = mode_acc && !bus_wdata[0];
  wire start_req = mode_acc && bus_wdata[0] && !en_q;
  wire reload_now = start_req || kick_acc;

  always_comb begin
    case (psel_q)
      2'd0: pre_lim = 12'd7;
      2'd1: pre_lim = 12'd63;
      2'd2: pre_lim = 12'd511;
      default: pre_lim = 12'd4095;
    endcase
  end

  wire tick   = en_q && pre_q == pre_lim;
  wire expire = tick && cnt_q <= CNT_W'(1) && !zflag_q && !reload_now && !stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rst_en_q <= 1'b0; irq_en_q <= 1'b0; len_q <= 2'd0;
    end else if (mode_acc) begin
      en_q     <= bus_wdata[0];
      rst_en_q <= bus_wdata[1];
      irq_en_q <= bus_wdata[2];
      len_q    <= bus_wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0; psel_q <= 2'd0;
    end else if (ctrl_acc) begin
      reload_q <= bus_wdata[13:2];
      psel_q   <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; pre_q <= '0; zflag_q <= 1'b0;
    end else if (reload_now) begin
      cnt_q   <= {reload_q, {LOW_BITS{1'b0}}};
      pre_q   <= '0;
      zflag_q <= 1'b0;
    end else if (stop_req) begin
      pre_q   <= '0;
      zflag_q <= 1'b0;
    end else if (en_q) begin
      pre_q <= tick ? 12'd0 : pre_q + 12'd1;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (expire) zflag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_q <= '0;
    else if (expire && rst_en_q) pulse_q <= 5'd2 << len_q;
    else if (pulse_q != '0)     pulse_q <= pulse_q - 5'd1;
  end

  assign wdt_rst_out = pulse_q != '0;
  assign wdt_irq     = zflag_q && irq_en_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (reg_idx)
        2'd0: bus_rdata = {26'd0, len_q, 1'b0, irq_en_q, rst_en_q, en_q};
        2'd1: bus_rdata = {18'd0, reload_q, psel_q};
        2'd3: bus_rdata = {31'd0, zflag_q};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module keyed_watchdog_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              en_q,
  input logic              rst_en_q,
  input logic              irq_en_q,
  input logic [1:0]        len_q,
  input logic [11:0]       reload_q,
  input logic [1:0]        psel_q,
  input logic              zflag_q,
  input logic              wdt_rst_out,
  input logic              wdt_irq
);
  logic [5:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (wdt_rst_out) run_q <= (run_q == 6'd63) ? run_q : run_q + 6'd1;
    else                 run_q <= '0;
  end

  assert_mode_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] != 12'hABC)
      |=> $stable({en_q, rst_en_q, irq_en_q, len_q}));

  assert_ctrl_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd1 && bus_wdata[25:14] != 12'h248)
      |=> $stable({reload_q, psel_q}));

  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd2 && bus_wdata == 32'h0000_1999) |=> !zflag_q);

  assert_flag_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zflag_q) |-> $past(en_q));

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> (zflag_q && irq_en_q));

  assert_pulse_at_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_out) |-> $rose(zflag_q));

  assert_pulse_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 6'd16);

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] == 12'hABC && !bus_wdata[0])
      |=> (!zflag_q && !en_q));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .en_q(en_q), .rst_en_q(rst_en_q), .irq_en_q(irq_en_q),
  .len_q(len_q), .reload_q(reload_q), .psel_q(psel_q), .zflag_q(zflag_q),
  .wdt_rst_out(wdt_rst_out), .wdt_irq(wdt_irq));

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int LB = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdt_rst_out, wdt_irq;
  int n_chk = 0, n_bad = 0;

  keyed_watchdog #(.ADDR_W(4), .LOW_BITS(LB)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wdt_rst_out(wdt_rst_out), .wdt_irq(wdt_irq));

  always #10 clk = ~clk;

  function automatic logic [31:0] mode_word(bit en, bit re, bit ie, logic [1:0] len);
    return {8'h00, 12'hABC, 6'd0, len, 1'b0, ie, re, en};
  endfunction
  function automatic logic [31:0] ctrl_word(logic [11:0] fld, logic [1:0] sel);
    return {6'd0, 12'h248, fld, sel};
  endfunction
  function automatic int period(int fld, int sel);
    return fld * (1 << LB) * (8 << (3 * sel));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic run_timeout(int fld, int sel, logic [1:0] len, bit re, bit ie, string tag);
    logic [31:0] st;
    int t, hi;
    t = period(fld, sel);
    wr(4'h4, ctrl_word(12'(fld), 2'(sel)));
    wr(4'h0, mode_word(1'b0, re, ie, len));
    wr(4'h0, mode_word(1'b1, re, ie, len));
    repeat (t - 1) @(posedge clk);
    @(negedge clk);
    rd(4'hC, st);
    check(st == 0 && !wdt_irq && !wdt_rst_out, {tag, " R4 early"}, st, 0);
    @(posedge clk); @(negedge clk);
    rd(4'hC, st);
    check(st == 1, {tag, " R5 flag at expiry"}, st, 1);
    check(wdt_irq == ie, {tag, " R6 irq"}, 32'(wdt_irq), 32'(ie));
    hi = 0;
    while (wdt_rst_out && hi < 40) begin hi++; @(negedge clk); end
    check(hi == (re ? (2 << len) : 0), {tag, " R7 pulse length"}, hi, re ? (2 << len) : 0);
    rd(4'hC, st);
    check(st == 1, {tag, " R5 flag sticky"}, st, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, prev_m, prev_c, junk;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd(4'h0, d); check(d == 0, "R9 mode reset", d, 0);
    rd(4'h4, d); check(d == 0, "R9 ctrl reset", d, 0);
    rd(4'hC, d); check(d == 0, "R9 status reset", d, 0);
    check(!wdt_irq && !wdt_rst_out, "R9 outputs reset", {wdt_irq, wdt_rst_out}, 0);

    wr(4'h0, mode_word(1'b0, 1'b1, 1'b1, 2'd2));
    wr(4'h4, ctrl_word(12'hA5C, 2'd3));
    rd(4'h0, d); check(d == 32'h26, "R1 keyed mode readback", d, 32'h26);
    rd(4'h4, d); check(d == {18'd0, 12'hA5C, 2'd3}, "R2 keyed ctrl readback", d, {18'd0, 12'hA5C, 2'd3});

    for (int i = 0; i < 20; i++) begin
      rd(4'h0, prev_m); rd(4'h4, prev_c);
      junk = $urandom;
      if (i % 2 == 0) begin
        if (junk[23:12] == 12'hABC) junk[12] = ~junk[12];
        wr(4'h0, junk); rd(4'h0, d);
        check(d == prev_m, "R1 unkeyed mode write ignored", d, prev_m);
      end else begin
        if (junk[25:14] == 12'h248) junk[14] = ~junk[14];
        wr(4'h4, junk); rd(4'h4, d);
        check(d == prev_c, "R2 unkeyed ctrl write ignored", d, prev_c);
      end
    end

    for (int i = 0; i < 6; i++)
      run_timeout($urandom_range(1, 3), $urandom_range(0, 1), 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "random");

    run_timeout(1, 2, 2'd3, 1'b1, 1'b1, "div512");
    run_timeout(1, 3, 2'd0, 1'b1, 1'b0, "div4096");
    run_timeout(2, 0, 2'd1, 1'b1, 1'b1, "len4");

    for (int i = 0; i < 4; i++) begin
      junk = $urandom;
      if (junk == 32'h1999) junk = 32'h1998;
      wr(4'h8, junk); rd(4'hC, d);
      check(d == 1, "R3 wrong restart word ignored", d, 1);
    end
    wr(4'h8, 32'h1999); rd(4'hC, d);
    check(d == 0 && !wdt_irq, "R3 restart clears flag", d, 0);

    repeat (period(2, 0) - 40) @(posedge clk);
    wr(4'h8, 32'h1999);
    repeat (period(2, 0) - 1) @(posedge clk); @(negedge clk);
    rd(4'hC, d); check(d == 0, "R3 restart reloads full count", d, 0);
    @(posedge clk); @(negedge clk);
    rd(4'hC, d); check(d == 1, "R3 expiry after restart", d, 1);

    wr(4'h0, mode_word(1'b0, 1'b1, 1'b1, 2'd1));
    rd(4'hC, d); check(d == 0 && !wdt_irq, "R8 disable clears flag", d, 0);
    repeat (period(2, 0) + 50) @(posedge clk); @(negedge clk);
    rd(4'hC, d); check(d == 0 && !wdt_rst_out, "R8 disabled does not expire", d, 0);
    wr(4'h0, mode_word(1'b1, 1'b1, 1'b1, 2'd1));
    repeat (period(2, 0) - 1) @(posedge clk); @(negedge clk);
    rd(4'hC, d); check(d == 0, "R8 re-enable full count", d, 0);
    @(posedge clk); @(negedge clk);
    rd(4'hC, d); check(d == 1 && wdt_irq, "R8 re-enable expiry", d, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule